// File: doc/BRIEF.md
# Dual-Clock FIFO with Loadable Threshold Flags

This block is a first-in first-out buffer for 9-bit words. The write port and the read port each run on their own clock, and the two clocks need no fixed relation. Writes are qualified by a primary enable and an auxiliary pin. The read side fetches a word into an output register only when both read enables are high. Four active-low flags report the fill level. Empty and almost-empty are produced in the read domain. Full and almost-full are produced in the write domain. Each domain sees the other's pointer through a Gray-coded two-flop synchroniser.

The auxiliary write pin has one of two roles. Its level is captured while reset is held. If it is high, it becomes a second write enable. If it is low, it becomes a load strobe. In that case successive strobed write-clock cycles place the data bus first into the almost-empty threshold and then into the almost-full threshold, and the sequence then wraps back. The output enable does not gate any pads. It only drives a valid indication, which is low where the output would otherwise float.

The depth is `2**AW` words and is set by a parameter. The default is kept at 1024 so that the behavioural array stays small. Setting `AW=14` gives 16384 words.

Top module: `dcfifo_pflags`

## Requirements
- R1: While reset is held and after it is released, with no traffic: `empty_n`=0, `aempty_n`=0, `full_n`=1, `afull_n`=1, and `q_out`=0.
- R2: The output register and read pointer advance only on a read-clock edge where `rd_en_a`=1, `rd_en_b`=1 and `empty_n`=1. A read attempted while empty is ignored.
- R3: A write attempted while `full_n`=0 is ignored. The stored contents and the write pointer are unchanged.
- R4: If `wr_aux` was high during reset (dual-enable mode), a word is written only when `wr_en_a`=1 and `wr_aux`=1 together.
- R5: If `wr_aux` was low during reset (load mode), a write-clock edge with `wr_aux`=1 loads `d_in` into the almost-empty threshold n. The next such edge loads the almost-full threshold m, and the one after that loads n again. Load cycles store nothing in the FIFO. Words are written with `wr_en_a`=1 and `wr_aux`=0.
- R6: After reset both thresholds equal the parameter `OFF_RST` (default 127).
- R7: Once settled, `aempty_n`=0 exactly when the stored word count is at most n.
- R8: Once settled, `afull_n`=0 exactly when the count plus m is at least the depth. `full_n`=0 exactly when the count equals the depth.
- R9: Words leave in the order they were written. After `empty_n` rises, a read on the next read-clock edge presents the oldest word on `q_out` after that edge.
- R10: `q_valid` is 1 when `oe_n`=0 and 0 when `oe_n`=1.
- R11: A write into an empty FIFO raises `empty_n` no later than the fourth read-clock edge after the write-clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain synchronously |
| wr_en_a | input | 1 | Primary write enable, active high |
| wr_aux | input | 1 | Second write enable or threshold load strobe, role fixed during reset |
| d_in | input | DW | Write data, also the threshold load value |
| rd_en_a | input | 1 | First read enable, active high |
| rd_en_b | input | 1 | Second read enable, active high |
| oe_n | input | 1 | Output enable, active low |
| q_out | output | DW | Output register contents |
| q_valid | output | 1 | High when the output would be driven, low for high impedance |
| empty_n | output | 1 | Empty flag, active low, read domain |
| aempty_n | output | 1 | Almost-empty flag, active low, read domain |
| full_n | output | 1 | Full flag, active low, write domain |
| afull_n | output | 1 | Almost-full flag, active low, write domain |

## Verification
The properties assume that `rst_n` is held for several cycles of both clocks and that `wr_aux` stays at its chosen level through that time and until the synchronised reset has been released. Without this, the captured mode is undefined. They also assume that thresholds are not reloaded while the read side is checking flags, because the almost-empty threshold crosses into the read domain as a quasi-static value. The stimulus holds `wr_aux` steady for four read-clock cycles beyond the release of `rst_n`. It loads thresholds only right after a reset, while the FIFO is empty. Before it compares any flag against a count, it waits ten read-clock cycles so that both synchronisers have settled.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  // role of the auxiliary write pin, captured during reset
  typedef enum logic {
    AUX_LOAD = 1'b0,
    AUX_WEN  = 1'b1
  } aux_mode_e;

  // which threshold the next load strobe writes
  typedef enum logic {
    LD_LOW  = 1'b0,
    LD_HIGH = 1'b1
  } ld_sel_e;
endpackage

// File: rtl/dcf_rst_sync.sv
module dcf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage  <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      stage  <= 1'b1;
      srst_n <= stage;
    end
  end
endmodule

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int AW      = 10,
  parameter int DW      = 9,
  parameter int OFF_RST = 127
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en_a,
  input  logic          wr_aux,
  input  logic [DW-1:0] d_in,
  input  logic [AW:0]   rgray_s,
  output logic          wr_go,
  output logic [AW:0]   wbin,
  output logic [AW:0]   wgray,
  output logic          full_n,
  output logic          afull_n,
  output logic [DW-1:0] off_low
);
  localparam int DEPTH = 1 << AW;
  localparam int XW    = AW + DW + 2;

  aux_mode_e     mode;
  ld_sel_e       ld_sel, ld_sel_nx;
  logic [DW-1:0] off_high, off_low_nx, off_high_nx;
  logic [AW:0]   wbin_nx, wgray_nx, rbin_s, used_nx;
  logic          full_n_nx, afull_n_nx, load_go, wr_req;

  // role of the auxiliary pin is latched while reset is held
  always_ff @(posedge wclk) begin
    if (!wrst_n) mode <= aux_mode_e'(wr_aux);
  end

  always_comb begin
    for (int i = 0; i <= AW; i++) rbin_s[i] = ^(rgray_s >> i);
  end

  always_comb begin
    load_go  = (mode == AUX_LOAD) && wr_aux;
    wr_req   = (mode == AUX_WEN) ? (wr_en_a && wr_aux) : (wr_en_a && !wr_aux);
    wr_go    = wr_req && full_n;
    wbin_nx  = wbin + {{AW{1'b0}}, wr_go};
    wgray_nx = wbin_nx ^ (wbin_nx >> 1);
    full_n_nx = (wgray_nx != {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
    used_nx  = wbin_nx - rbin_s;
    afull_n_nx = !((XW'(used_nx) + XW'(off_high)) >= XW'(DEPTH));
    off_low_nx  = off_low;
    off_high_nx = off_high;
    ld_sel_nx   = ld_sel;
    if (load_go) begin
      if (ld_sel == LD_LOW) begin
        off_low_nx = d_in;
        ld_sel_nx  = LD_HIGH;
      end else begin
        off_high_nx = d_in;
        ld_sel_nx   = LD_LOW;
      end
    end
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin     <= '0;
      wgray    <= '0;
      full_n   <= 1'b1;
      afull_n  <= 1'b1;
      off_low  <= DW'(OFF_RST);
      off_high <= DW'(OFF_RST);
      ld_sel   <= LD_LOW;
    end else begin
      wbin     <= wbin_nx;
      wgray    <= wgray_nx;
      full_n   <= full_n_nx;
      afull_n  <= afull_n_nx;
      off_low  <= off_low_nx;
      off_high <= off_high_nx;
      ld_sel   <= ld_sel_nx;
    end
  end
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl #(
  parameter int AW = 10,
  parameter int DW = 9
) (
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_en_a,
  input  logic          rd_en_b,
  input  logic [AW:0]   wgray_s,
  input  logic [DW-1:0] off_low,
  input  logic [DW-1:0] rdata,
  output logic [AW:0]   rbin,
  output logic [AW:0]   rgray,
  output logic          empty_n,
  output logic          aempty_n,
  output logic [DW-1:0] q_reg
);
  localparam int XW = AW + DW + 2;

  logic [AW:0]   rbin_nx, rgray_nx, wbin_s, level_nx;
  logic [DW-1:0] q_nx;
  logic          rd_go, empty_n_nx, aempty_n_nx;

  always_comb begin
    for (int i = 0; i <= AW; i++) wbin_s[i] = ^(wgray_s >> i);
  end

  always_comb begin
    rd_go       = rd_en_a && rd_en_b && empty_n;
    rbin_nx     = rbin + {{AW{1'b0}}, rd_go};
    rgray_nx    = rbin_nx ^ (rbin_nx >> 1);
    empty_n_nx  = (rgray_nx != wgray_s);
    level_nx    = wbin_s - rbin_nx;
    aempty_n_nx = XW'(level_nx) > XW'(off_low);
    q_nx        = rd_go ? rdata : q_reg;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
      q_reg    <= '0;
    end else begin
      rbin     <= rbin_nx;
      rgray    <= rgray_nx;
      empty_n  <= empty_n_nx;
      aempty_n <= aempty_n_nx;
      q_reg    <= q_nx;
    end
  end
endmodule

// File: rtl/dcfifo_pflags.sv
module dcfifo_pflags #(
  parameter int AW      = 10,
  parameter int DW      = 9,
  parameter int OFF_RST = 127
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wr_en_a,
  input  logic          wr_aux,
  input  logic [DW-1:0] d_in,
  input  logic          rd_en_a,
  input  logic          rd_en_b,
  input  logic          oe_n,
  output logic [DW-1:0] q_out,
  output logic          q_valid,
  output logic          empty_n,
  output logic          aempty_n,
  output logic          full_n,
  output logic          afull_n
);
  localparam int DEPTH = 1 << AW;

  logic          wrst_n, rrst_n, wr_go;
  logic [AW:0]   wr_ptr, rd_ptr, wgray, rgray, wgray_s, rgray_s;
  logic [DW-1:0] off_low, rdata, q_reg;
  logic [DW-1:0] mem [DEPTH];

  dcf_rst_sync u_wrst (.clk(wclk), .arst_n(rst_n), .srst_n(wrst_n));
  dcf_rst_sync u_rrst (.clk(rclk), .arst_n(rst_n), .srst_n(rrst_n));

  dcf_sync #(.W(AW+1)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));
  dcf_sync #(.W(AW+1)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));

  dcf_wr_ctl #(.AW(AW), .DW(DW), .OFF_RST(OFF_RST)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en_a(wr_en_a), .wr_aux(wr_aux),
    .d_in(d_in), .rgray_s(rgray_s), .wr_go(wr_go), .wbin(wr_ptr),
    .wgray(wgray), .full_n(full_n), .afull_n(afull_n), .off_low(off_low)
  );

  dcf_rd_ctl #(.AW(AW), .DW(DW)) u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b),
    .wgray_s(wgray_s), .off_low(off_low), .rdata(rdata), .rbin(rd_ptr),
    .rgray(rgray), .empty_n(empty_n), .aempty_n(aempty_n), .q_reg(q_reg)
  );

  // storage array, written in the write domain, read asynchronously
  always_ff @(posedge wclk) begin
    if (wr_go) mem[wr_ptr[AW-1:0]] <= d_in;
  end

  assign rdata   = mem[rd_ptr[AW-1:0]];
  assign q_out   = q_reg;
  assign q_valid = !oe_n;
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
  parameter int AW = 10,
  parameter int DW = 9
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          rd_en_a,
  input logic          rd_en_b,
  input logic [DW-1:0] q_out,
  input logic          empty_n,
  input logic          aempty_n,
  input logic          full_n,
  input logic          afull_n,
  input logic [AW:0]   wr_ptr,
  input logic [AW:0]   rd_ptr
);
  // R2: no fetch while empty
  p_empty_holds_q_r2: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |=> $stable(q_out));

  // R2: both read enables are needed
  p_two_enables_r2: assert property (@(posedge rclk) disable iff (!rst_n)
    !(rd_en_a && rd_en_b) |=> ($stable(q_out) && $stable(rd_ptr)));

  p_empty_holds_ptr_r2: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |=> $stable(rd_ptr));

  // R3: write pointer frozen while full
  p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |=> $stable(wr_ptr));

  // R7: empty implies almost-empty
  p_empty_aempty_r7: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);

  // R8: full implies almost-full
  p_full_afull_r8: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |-> !afull_n);

  // R9: read pointer steps by at most one word per edge
  p_rd_step_r9: assert property (@(posedge rclk) disable iff (!rst_n)
    ((AW+1)'(rd_ptr - $past(rd_ptr)) <= (AW+1)'(1)));
endmodule

bind dcfifo_pflags dcf_checker #(.AW(AW), .DW(DW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .rd_en_a(rd_en_a),
  .rd_en_b(rd_en_b), .q_out(q_out), .empty_n(empty_n),
  .aempty_n(aempty_n), .full_n(full_n), .afull_n(afull_n),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
);

// File: tb/dcfifo_pflags_test.sv
module dcfifo_pflags_test;
  localparam int AW    = 5;
  localparam int DW    = 9;
  localparam int DEPTH = 1 << AW;
  localparam int OFFR  = 7;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic wr_en_a = 1'b0, wr_aux = 1'b0, rd_en_a = 1'b0, rd_en_b = 1'b0, oe_n = 1'b0;
  logic [DW-1:0] d_in = '0;
  logic [DW-1:0] q_out;
  logic q_valid, empty_n, aempty_n, full_n, afull_n;

  int  n_chk = 0, n_err = 0;
  bit  dual = 1'b0;
  bit  done = 1'b0;

  always #2 wclk = ~wclk;    // 250 MHz
  always #3.5 rclk = ~rclk;

  dcfifo_pflags #(.AW(AW), .DW(DW), .OFF_RST(OFFR)) uut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en_a(wr_en_a),
    .wr_aux(wr_aux), .d_in(d_in), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b),
    .oe_n(oe_n), .q_out(q_out), .q_valid(q_valid), .empty_n(empty_n),
    .aempty_n(aempty_n), .full_n(full_n), .afull_n(afull_n)
  );

  // fields: n[31:24] m[23:16] words[15:8] expect{full_n,afull_n,aempty_n,empty_n}[3:0]
  localparam logic [31:0] VEC [8] = '{
    {8'd3,  8'd4,  8'd3,  8'b1101},
    {8'd3,  8'd4,  8'd4,  8'b1111},
    {8'd0,  8'd1,  8'd31, 8'b1011},
    {8'd5,  8'd2,  8'd32, 8'b0011},
    {8'd10, 8'd10, 8'd22, 8'b1011},
    {8'd10, 8'd10, 8'd21, 8'b1111},
    {8'd20, 8'd0,  8'd20, 8'b1101},
    {8'd0,  8'd0,  8'd0,  8'b1100}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic aux_lvl);
    @(negedge rclk);
    rst_n = 1'b0; wr_en_a = 1'b0; rd_en_a = 1'b0; rd_en_b = 1'b0;
    wr_aux = aux_lvl;
    repeat (4) @(negedge rclk);
    rst_n = 1'b1;
    repeat (4) @(negedge rclk);
    @(negedge wclk);
    wr_aux = 1'b0;
    dual = aux_lvl;
  endtask

  task automatic push_raw(input logic en, input logic aux, input int val);
    @(negedge wclk);
    wr_en_a = en; wr_aux = aux; d_in = DW'(val);
    @(negedge wclk);
    wr_en_a = 1'b0; wr_aux = 1'b0;
  endtask

  task automatic push(input int val);
    push_raw(1'b1, dual, val);
  endtask

  task automatic load(input int val);
    push_raw(1'b0, 1'b1, val);
  endtask

  task automatic pop(output int val);
    @(negedge rclk);
    rd_en_a = 1'b1; rd_en_b = 1'b1;
    @(negedge rclk);
    rd_en_a = 1'b0; rd_en_b = 1'b0;
    val = int'(q_out);
  endtask

  task automatic settle();
    repeat (10) @(negedge rclk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      report();
    end
  end

  initial begin
    int v, lat;
    // R1 reset state, R10 output enable
    do_reset(1'b1);
    chk("R1 empty_n", int'(empty_n), 0);
    chk("R1 aempty_n", int'(aempty_n), 0);
    chk("R1 full_n", int'(full_n), 1);
    chk("R1 afull_n", int'(afull_n), 1);
    chk("R1 q_out", int'(q_out), 0);
    chk("R10 q_valid oe low", int'(q_valid), 1);
    oe_n = 1'b1; #1;
    chk("R10 q_valid oe high", int'(q_valid), 0);
    oe_n = 1'b0;

    // R4 second enable missing: nothing stored
    push_raw(1'b1, 1'b0, 9'h0A5);
    settle();
    chk("R4 write without aux ignored", int'(empty_n), 0);

    // R11 latency of empty_n after a write
    push(9'h0A5);
    lat = 0;
    while (!empty_n && lat < 8) begin
      @(negedge rclk);
      lat++;
    end
    chk("R11 empty_n latency within 4", int'(lat <= 4), 1);

    // R2 one read enable only
    @(negedge rclk); rd_en_a = 1'b1;
    @(negedge rclk); rd_en_a = 1'b0;
    chk("R2 single enable q_out", int'(q_out), 0);
    chk("R2 single enable empty_n", int'(empty_n), 1);
    // R9 first word on the edge after empty_n rose
    pop(v);
    chk("R9 first word", v, 9'h0A5);
    chk("R2 empty after last read", int'(empty_n), 0);
    // R2 read while empty ignored
    pop(v);
    chk("R2 read on empty holds q", v, 9'h0A5);
    push(9'h13C);
    settle();
    pop(v);
    chk("R2 pointer held on empty read", v, 9'h13C);

    // R6 default thresholds (OFF_RST) with R7/R8
    do_reset(1'b1);
    for (int i = 0; i < 7; i++) push(i);
    settle();
    chk("R6 aempty_n at n words", int'(aempty_n), 0);
    push(7);
    settle();
    chk("R6 aempty_n at n+1 words", int'(aempty_n), 1);
    for (int i = 8; i < 24; i++) push(i);
    settle();
    chk("R6 afull_n at depth-m-1", int'(afull_n), 1);
    push(24);
    settle();
    chk("R6 afull_n at depth-m", int'(afull_n), 0);

    // R5 load sequence wraps and stores no words
    do_reset(1'b0);
    load(2); load(30); load(5);
    settle();
    chk("R5 loads store nothing", int'(empty_n), 0);
    for (int i = 0; i < 5; i++) push(i);
    settle();
    chk("R5 wrapped n at 5 words", int'(aempty_n), 0);
    push(5);
    settle();
    chk("R5 wrapped n at 6 words", int'(aempty_n), 1);
    chk("R5 m=30 afull_n", int'(afull_n), 0);

    // table: thresholds, fill level, flags, then drain in order
    for (int e = 0; e < 8; e++) begin
      int n, m, k;
      logic [3:0] ex;
      n  = int'(VEC[e][31:24]);
      m  = int'(VEC[e][23:16]);
      k  = int'(VEC[e][15:8]);
      ex = VEC[e][3:0];
      do_reset(1'b0);
      load(n); load(m);
      for (int i = 0; i < k; i++) push((e * 37 + i * 5 + 1) & 511);
      settle();
      chk($sformatf("R8 full_n row %0d", e), int'(full_n), int'(ex[3]));
      chk($sformatf("R8 afull_n row %0d", e), int'(afull_n), int'(ex[2]));
      chk($sformatf("R7 aempty_n row %0d", e), int'(aempty_n), int'(ex[1]));
      chk($sformatf("R7 empty_n row %0d", e), int'(empty_n), int'(ex[0]));
      if (k == DEPTH) begin
        push(9'h1FF);
        settle();
        chk("R3 full_n after extra write", int'(full_n), 0);
      end
      for (int i = 0; i < k; i++) begin
        pop(v);
        chk($sformatf("R9 order row %0d word %0d", e, i), v, (e * 37 + i * 5 + 1) & 511);
      end
      settle();
      chk($sformatf("R3 drained empty row %0d", e), int'(empty_n), 0);
      chk($sformatf("R7 drained aempty row %0d", e), int'(aempty_n), 0);
    end

    done = 1'b1;
    report();
  end
endmodule